// File: doc/BRIEF.md
# Tagged half-word store unit

This block forms memory addresses, write data and per-half write enables for a memory made of 32-bit words, starting from 16-bit register values. It handles full-word stores whose upper half carries a tag built from the program counter and a 2-bit identifier, stores into only the lower or only the upper half of a word, and loads that return one half of a word. A word-offset register supports streaming stores. The streaming half store fills the lower half, then the upper half of the same word, and then moves on to the next word. The streaming full store moves on one word on every call.

Each operation is accepted in one cycle while the unit is idle. The unit then walks through a fixed sequence of states. The memory is shared with higher-priority host processors, so the memory access is modelled as a request that waits on a ready input. The access holds its address and data until the memory grants it.

States: `S_IDLE` waits for `op_valid`. `S_ADDR` registers the effective address, write data and enables. `S_ACCESS` drives `mem_req` and stays there while `mem_ready` is low. `S_DONE` pulses `done` and updates the offset register. Transitions: S_IDLE→S_ADDR on `op_valid`. S_ADDR→S_ACCESS always. S_ACCESS→S_DONE when `mem_ready` is high, or at once for operations that do not touch memory. S_DONE→S_IDLE always.

Top module: `hw_store_unit`

## Requirements
- R1: After reset `busy`, `done`, `mem_req` and `load_valid` are low, the word-offset register is 0 and the streaming half selection points at the lower half.
- R2: An operation is accepted on a clock edge where `op_valid` is high and the unit is idle. `busy` is high from the next cycle. `done` is high for exactly one cycle, three cycles after the accepting edge when there is no stall. `op_valid` seen while busy is ignored.
- R3: While `mem_req` is high and `mem_ready` is low, the request, address and write data hold. Each such cycle delays `done` by one cycle.
- R4: For non-streaming memory operations the word address is `base_val + (byte_off >>> 2)`, where `byte_off` is signed, taken modulo 2^ADDR_W.
- R5: Op code 1 (tagged store) writes both halves with `{pc[10:0], 3'b000, base_idx[1:0], src_val[15:0]}`.
- R6: Op code 4 (labelled full store) writes both halves with `{pc[10:0], 3'b000, label[1:0], src_val[15:0]}`.
- R7: Op code 2 writes only bits 15:0 and op code 3 writes only bits 31:16; the other half of the word is unchanged. The half written is `src_val` when `use_label` is 0, or `{label, src_val[13:0]}` when it is 1.
- R8: Op code 5 (set offset) loads the offset register with `byte_off >>> 2` and returns the half selection to the lower half. It makes no memory request.
- R9: Op code 6 (streaming half store) writes at `base_val + offset` the half chosen by the half selection, formatted as in R7. It writes the lower half first and the upper half on the next call, and the offset then advances by one word.
- R10: Op code 7 (streaming full store) writes the R6 word at `base_val + offset` and advances the offset by one word on every call.
- R11: Op code 8 returns bits 15:0 and op code 9 returns bits 31:16 of the addressed word on `load_data` while `load_valid` and `done` are high. Loads assert no write enable.
- R12: Op codes 0 and 10 to 15 complete in the R2 time with no memory request, no write and no change to the offset register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation request |
| op_code | input | 4 | Operation code (see R5 to R12) |
| src_val | input | 16 | Value to store |
| base_val | input | 11 | Word address held in the base register |
| base_idx | input | 2 | Index of the base register, used in the R5 tag |
| byte_off | input | 13 | Signed byte offset |
| label | input | 2 | User identifier |
| use_label | input | 1 | Put the identifier into half-word stores |
| pc | input | 11 | Program counter in words |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory access request |
| mem_ready | input | 1 | Memory granted this cycle |
| mem_addr | output | 11 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_we_lo | output | 1 | Write enable for bits 15:0 |
| mem_we_hi | output | 1 | Write enable for bits 31:16 |
| mem_rdata | input | 32 | Read data, valid while `mem_req` and `mem_ready` are high |
| load_valid | output | 1 | `load_data` is valid |
| load_data | output | 16 | Loaded half-word |

## Verification
Directed sequences set the offset and then issue four streaming half stores, to show that each word is filled lower half first, then upper half, and that a new offset in the middle of a pair sends the next store back to the lower half. Negative offsets and a base near the top of memory show that the address is sign-extended and wraps. Stalls of several cycles show that a held request is not confused with a repeated write. Random mixes of every op code with random stalls then compare each written word against a merge of the old word with the expected half or tag, so that a write into the wrong half shows up as a corrupted neighbour half.

// File: rtl/hws_pkg.sv
package hws_pkg;

    localparam logic [3:0] OP_ST_TAG    = 4'd1;
    localparam logic [3:0] OP_ST_LO     = 4'd2;
    localparam logic [3:0] OP_ST_HI     = 4'd3;
    localparam logic [3:0] OP_ST_LBL    = 4'd4;
    localparam logic [3:0] OP_SET_OFS   = 4'd5;
    localparam logic [3:0] OP_STRM_HALF = 4'd6;
    localparam logic [3:0] OP_STRM_FULL = 4'd7;
    localparam logic [3:0] OP_LD_LO     = 4'd8;
    localparam logic [3:0] OP_LD_HI     = 4'd9;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ADDR,
        S_ACCESS,
        S_DONE
    } state_e;

    typedef struct packed {
        logic store;
        logic load;
        logic full;
        logic hi;
        logic tag_lbl;
        logic stream;
        logic set_ofs;
    } op_cls_t;

    function automatic op_cls_t classify(input logic [3:0] op);
        op_cls_t c;
        c = '0;
        case (op)
            OP_ST_TAG:    begin c.store = 1'b1; c.full = 1'b1; end
            OP_ST_LO:     begin c.store = 1'b1; end
            OP_ST_HI:     begin c.store = 1'b1; c.hi = 1'b1; end
            OP_ST_LBL:    begin c.store = 1'b1; c.full = 1'b1; c.tag_lbl = 1'b1; end
            OP_SET_OFS:   begin c.set_ofs = 1'b1; end
            OP_STRM_HALF: begin c.store = 1'b1; c.stream = 1'b1; end
            OP_STRM_FULL: begin c.store = 1'b1; c.full = 1'b1; c.tag_lbl = 1'b1; c.stream = 1'b1; end
            OP_LD_LO:     begin c.load = 1'b1; end
            OP_LD_HI:     begin c.load = 1'b1; c.hi = 1'b1; end
            default:      c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/hws_addr_gen.sv
module hws_addr_gen #(
    parameter int ADDR_W = 11,
    parameter int OFF_W  = 13
) (
    input  logic [ADDR_W-1:0]       base_val,
    input  logic signed [OFF_W-1:0] byte_off,
    input  logic [ADDR_W-1:0]       ofs_word,
    input  logic                    use_stream,
    output logic [ADDR_W-1:0]       off_word,
    output logic [ADDR_W-1:0]       addr
);
    logic signed [OFF_W-1:0] shifted;

    always_comb begin
        shifted  = byte_off >>> 2;
        off_word = ADDR_W'(shifted);
        addr     = base_val + (use_stream ? ofs_word : off_word);
    end
endmodule

// File: rtl/hws_wdata_fmt.sv
module hws_wdata_fmt #(
    parameter int DATA_W = 16,
    parameter int PC_W   = 11,
    parameter int WORD_W = 2 * DATA_W
) (
    input  logic              store,
    input  logic              full,
    input  logic              hi_sel,
    input  logic              tag_lbl,
    input  logic              half_lbl,
    input  logic [DATA_W-1:0] val,
    input  logic [1:0]        idx,
    input  logic [1:0]        lbl,
    input  logic [PC_W-1:0]   pc,
    output logic [WORD_W-1:0] wdata,
    output logic              we_lo,
    output logic              we_hi
);
    localparam int PAD_W = WORD_W - PC_W - 2 - DATA_W;

    logic [DATA_W-1:0] half;
    logic [1:0]        tag_id;

    always_comb begin
        half   = half_lbl ? {lbl, val[DATA_W-3:0]} : val;
        tag_id = tag_lbl ? lbl : idx;
        if (full) begin
            wdata = {pc, {PAD_W{1'b0}}, tag_id, val};
        end else if (hi_sel) begin
            wdata = {half, {DATA_W{1'b0}}};
        end else begin
            wdata = {{DATA_W{1'b0}}, half};
        end
        we_lo = store && (full || !hi_sel);
        we_hi = store && (full || hi_sel);
    end
endmodule

// File: rtl/hws_stream_ctr.sv
module hws_stream_ctr #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              half_step,
    input  logic              full_step,
    output logic [ADDR_W-1:0] ofs,
    output logic              half_sel
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ofs      <= '0;
            half_sel <= 1'b0;
        end else if (load_en) begin
            ofs      <= load_val;
            half_sel <= 1'b0;
        end else if (full_step) begin
            ofs      <= ofs + 1'b1;
        end else if (half_step) begin
            if (half_sel) begin
                ofs      <= ofs + 1'b1;
                half_sel <= 1'b0;
            end else begin
                half_sel <= 1'b1;
            end
        end
    end

    // R8: a new offset always restarts at the lower half
    p_sel_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (!half_sel && ofs == $past(load_val)));

    // R9: the first half store of a pair keeps the word and flips the half
    p_half_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (half_step && !half_sel && !load_en && !full_step) |=> (half_sel && $stable(ofs)));

    // R10: every streaming full store advances one word
    p_ofs_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (full_step && !load_en) |=> ofs == $past(ofs) + 1'b1);
endmodule

// File: rtl/hw_store_unit.sv
module hw_store_unit
    import hws_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int OFF_W  = 13,
    parameter int DATA_W = 16,
    parameter int PC_W   = 11,
    localparam int WORD_W = 2 * DATA_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    op_valid,
    input  logic [3:0]              op_code,
    input  logic [DATA_W-1:0]       src_val,
    input  logic [ADDR_W-1:0]       base_val,
    input  logic [1:0]              base_idx,
    input  logic signed [OFF_W-1:0] byte_off,
    input  logic [1:0]              label,
    input  logic                    use_label,
    input  logic [PC_W-1:0]         pc,
    output logic                    busy,
    output logic                    done,
    output logic                    mem_req,
    input  logic                    mem_ready,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [WORD_W-1:0]       mem_wdata,
    output logic                    mem_we_lo,
    output logic                    mem_we_hi,
    input  logic [WORD_W-1:0]       mem_rdata,
    output logic                    load_valid,
    output logic [DATA_W-1:0]       load_data
);
    state_e state, state_nx;

    logic [3:0]              op_q;
    logic [DATA_W-1:0]       val_q;
    logic [ADDR_W-1:0]       base_q;
    logic [1:0]              idx_q;
    logic signed [OFF_W-1:0] off_q;
    logic [1:0]              lbl_q;
    logic                    ul_q;
    logic [PC_W-1:0]         pc_q;
    op_cls_t                 cls;

    logic [ADDR_W-1:0] addr_c, off_word_c, ofs_w;
    logic              half_sel;
    logic [WORD_W-1:0] wdata_c, wdata_q;
    logic              we_lo_c, we_hi_c, we_lo_q, we_hi_q;
    logic [DATA_W-1:0] load_q;
    logic              uses_mem;

    assign cls      = classify(op_q);
    assign uses_mem = cls.store || cls.load;

    hws_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_addr (
        .base_val  (base_q),
        .byte_off  (off_q),
        .ofs_word  (ofs_w),
        .use_stream(cls.stream),
        .off_word  (off_word_c),
        .addr      (addr_c)
    );

    hws_wdata_fmt #(.DATA_W(DATA_W), .PC_W(PC_W), .WORD_W(WORD_W)) u_fmt (
        .store   (cls.store),
        .full    (cls.full),
        .hi_sel  (cls.stream ? half_sel : cls.hi),
        .tag_lbl (cls.tag_lbl),
        .half_lbl(ul_q),
        .val     (val_q),
        .idx     (idx_q),
        .lbl     (lbl_q),
        .pc      (pc_q),
        .wdata   (wdata_c),
        .we_lo   (we_lo_c),
        .we_hi   (we_hi_c)
    );

    hws_stream_ctr #(.ADDR_W(ADDR_W)) u_strm (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (state == S_DONE && cls.set_ofs),
        .load_val (off_word_c),
        .half_step(state == S_DONE && cls.store && cls.stream && !cls.full),
        .full_step(state == S_DONE && cls.store && cls.stream && cls.full),
        .ofs      (ofs_w),
        .half_sel (half_sel)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (op_valid) state_nx = S_ADDR;
            S_ADDR:   state_nx = S_ACCESS;
            S_ACCESS: if (!uses_mem || mem_ready) state_nx = S_DONE;
            S_DONE:   state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    // operand capture, address/data staging, load capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= '0;
            val_q   <= '0;
            base_q  <= '0;
            idx_q   <= '0;
            off_q   <= '0;
            lbl_q   <= '0;
            ul_q    <= 1'b0;
            pc_q    <= '0;
            mem_addr <= '0;
            wdata_q <= '0;
            we_lo_q <= 1'b0;
            we_hi_q <= 1'b0;
            load_q  <= '0;
        end else begin
            if (state == S_IDLE && op_valid) begin
                op_q   <= op_code;
                val_q  <= src_val;
                base_q <= base_val;
                idx_q  <= base_idx;
                off_q  <= byte_off;
                lbl_q  <= label;
                ul_q   <= use_label;
                pc_q   <= pc;
            end
            if (state == S_ADDR) begin
                mem_addr <= addr_c;
                wdata_q  <= wdata_c;
                we_lo_q  <= we_lo_c;
                we_hi_q  <= we_hi_c;
            end
            if (state == S_ACCESS && mem_ready && cls.load) begin
                load_q <= cls.hi ? mem_rdata[WORD_W-1:DATA_W] : mem_rdata[DATA_W-1:0];
            end
        end
    end

    // outputs from state
    always_comb begin
        busy       = (state != S_IDLE);
        mem_req    = (state == S_ACCESS) && uses_mem;
        mem_we_lo  = mem_req && we_lo_q;
        mem_we_hi  = mem_req && we_hi_q;
        mem_wdata  = wdata_q;
        done       = (state == S_DONE);
        load_valid = done && cls.load;
        load_data  = load_q;
    end

    // R2: accepted request makes the unit busy on the next cycle
    p_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !busy) |=> busy);

    // R2: completion is a single-cycle pulse
    p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3: a refused request holds its address and data
    p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));

    // R11: loads never write
    p_load_nowrite_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && cls.load) |-> (!mem_we_lo && !mem_we_hi));

    // R12: completion follows a granted access or a non-memory op
    p_done_path_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(state == S_ACCESS && (!uses_mem || mem_ready)));
endmodule

// File: tb/hw_store_unit_tb.sv
module hw_store_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid;
    logic [3:0]  op_code;
    logic [15:0] src_val;
    logic [10:0] base_val;
    logic [1:0]  base_idx;
    logic signed [12:0] byte_off;
    logic [1:0]  label;
    logic        use_label;
    logic [10:0] pc;
    logic        busy, done, mem_req, mem_ready, mem_we_lo, mem_we_hi, load_valid;
    logic [10:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic [15:0] load_data;

    logic [31:0] mem [0:2047];
    int stall_left = 0;
    int wr_cnt = 0;
    int req_cnt = 0;
    int n_chk = 0;
    int n_fail = 0;
    int exp_ofs = 0;
    bit exp_tog = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hw_store_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .src_val(src_val), .base_val(base_val), .base_idx(base_idx),
        .byte_off(byte_off), .label(label), .use_label(use_label), .pc(pc),
        .busy(busy), .done(done), .mem_req(mem_req), .mem_ready(mem_ready),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we_lo(mem_we_lo),
        .mem_we_hi(mem_we_hi), .mem_rdata(mem_rdata), .load_valid(load_valid),
        .load_data(load_data)
    );

    assign mem_ready = (stall_left == 0);
    assign mem_rdata = mem[mem_addr];

    always @(posedge clk) begin
        if (mem_req) req_cnt <= req_cnt + 1;
        if (mem_req && mem_ready) begin
            if (mem_we_lo) mem[mem_addr][15:0]  <= mem_wdata[15:0];
            if (mem_we_hi) mem[mem_addr][31:16] <= mem_wdata[31:16];
            if (mem_we_lo || mem_we_hi) wr_cnt <= wr_cnt + 1;
        end
        if (mem_req && stall_left > 0) stall_left <= stall_left - 1;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit is_store(input logic [3:0] op);
        return (op >= 4'd1 && op <= 4'd4) || op == 4'd6 || op == 4'd7;
    endfunction

    function automatic bit is_load(input logic [3:0] op);
        return op == 4'd8 || op == 4'd9;
    endfunction

    function automatic logic [31:0] exp_word(input logic [3:0] op, input logic [31:0] old,
            input logic [15:0] v, input logic [1:0] ix, input logic [1:0] lb, input bit ul,
            input logic [10:0] p, input bit tog);
        logic [15:0] h;
        h = ul ? {lb, v[13:0]} : v;
        case (op)
            4'd1:       return {p, 3'b000, ix, v};
            4'd4, 4'd7: return {p, 3'b000, lb, v};
            4'd2:       return {old[31:16], h};
            4'd3:       return {h, old[15:0]};
            4'd6:       return tog ? {h, old[15:0]} : {old[31:16], h};
            default:    return old;
        endcase
    endfunction

    task automatic run_op(input logic [3:0] op, input logic [15:0] v, input logic [10:0] b,
            input logic [1:0] ix, input logic signed [12:0] off, input logic [1:0] lb,
            input bit ul, input logic [10:0] p, input int stalls, input string req);
        int ea, n, wc0, rc0, lat;
        logic [31:0] old, expw;
        bit mem_op;
        mem_op = is_store(op) || is_load(op);
        if (op == 4'd6 || op == 4'd7) ea = (int'(b) + exp_ofs) & 2047;
        else ea = (int'(b) + (int'(off) >>> 2)) & 2047;
        old  = mem[ea];
        expw = exp_word(op, old, v, ix, lb, ul, p, exp_tog);
        wc0 = wr_cnt;
        rc0 = req_cnt;
        lat = mem_op ? 3 + stalls : 3;
        @(negedge clk);
        stall_left = mem_op ? stalls : 0;
        op_valid = 1'b1; op_code = op; src_val = v; base_val = b; base_idx = ix;
        byte_off = off; label = lb; use_label = ul; pc = p;
        @(posedge clk);
        n = 0;
        do begin
            @(negedge clk);
            op_valid = 1'b0;
            n++;
        end while (!done && n < 40);
        chk(n == lat, {req, " R2 R3 latency"}, n, lat);
        if (is_store(op)) begin
            chk(mem[ea] == expw, {req, " stored word"}, mem[ea], expw);
            chk(wr_cnt == wc0 + 1, {req, " one write"}, wr_cnt, wc0 + 1);
        end else begin
            chk(wr_cnt == wc0, {req, " no write"}, wr_cnt, wc0);
        end
        if (is_load(op)) begin
            logic [15:0] eh;
            eh = (op == 4'd9) ? mem[ea][31:16] : mem[ea][15:0];
            chk(load_valid && load_data == eh, {req, " R11 load data"}, {15'd0, load_valid, load_data}, {16'h0001, eh});
        end
        if (!mem_op) chk(req_cnt == rc0, {req, " R8 R12 no request"}, req_cnt, rc0);
        if (op == 4'd5) begin
            exp_ofs = (int'(off) >>> 2) & 2047;
            exp_tog = 0;
        end else if (op == 4'd7) begin
            exp_ofs = (exp_ofs + 1) & 2047;
        end else if (op == 4'd6) begin
            if (exp_tog) exp_ofs = (exp_ofs + 1) & 2047;
            exp_tog = !exp_tog;
        end
        @(posedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog R2 actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int cnt;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 2048; i++) mem[i] = 32'h0;
        rst_n = 1'b0; op_valid = 1'b0; op_code = '0; src_val = '0; base_val = '0;
        base_idx = '0; byte_off = '0; label = '0; use_label = 1'b0; pc = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !mem_req && !load_valid, "R1 idle outputs",
            {busy, done, mem_req, load_valid}, 32'h0);

        // R1: streaming half store after reset lands at base+0, lower half
        mem[100] = 32'hAAAA_BBBB;
        run_op(4'd6, 16'h1357, 11'd100, 2'd0, 13'sd0, 2'd0, 1'b0, 11'd0, 0, "R1 R9 first stream");
        chk(mem[100] == 32'hAAAA_1357, "R1 reset offset/half", mem[100], 32'hAAAA_1357);
        run_op(4'd6, 16'h2468, 11'd100, 2'd0, 13'sd0, 2'd0, 1'b0, 11'd0, 0, "R9 second stream");

        // R5 / R6
        run_op(4'd1, 16'hBEEF, 11'd200, 2'd3, 13'sd8, 2'd1, 1'b0, 11'h7FF, 0, "R5 tagged store");
        chk(mem[202] == 32'hFFE3_BEEF, "R5 tag layout", mem[202], 32'hFFE3_BEEF);
        run_op(4'd4, 16'h0001, 11'd300, 2'd0, 13'sd0, 2'd1, 1'b0, 11'd0, 0, "R6 labelled store");
        chk(mem[300] == 32'h0001_0001, "R6 label layout", mem[300], 32'h0001_0001);

        // R7 half stores
        mem[400] = 32'h1111_2222;
        run_op(4'd2, 16'hFFFF, 11'd400, 2'd0, 13'sd0, 2'd1, 1'b1, 11'd5, 0, "R7 lower labelled");
        chk(mem[400] == 32'h1111_7FFF, "R7 lower label form", mem[400], 32'h1111_7FFF);
        run_op(4'd3, 16'hCAFE, 11'd400, 2'd0, 13'sd0, 2'd2, 1'b0, 11'd5, 0, "R7 upper plain");
        chk(mem[400] == 32'hCAFE_7FFF, "R7 upper keeps lower", mem[400], 32'hCAFE_7FFF);

        // R4 negative offset and wrap
        run_op(4'd2, 16'h0A0A, 11'd500, 2'd0, -13'sd8, 2'd0, 1'b0, 11'd0, 0, "R4 negative offset");
        chk(mem[498][15:0] == 16'h0A0A, "R4 base-2", mem[498], 32'h0A0A);
        run_op(4'd2, 16'h0B0B, 11'h7FF, 2'd0, 13'sd16, 2'd0, 1'b0, 11'd0, 0, "R4 wrap");
        chk(mem[3][15:0] == 16'h0B0B, "R4 wrapped address", mem[3], 32'h0B0B);

        // R8 / R9 streaming sequence
        run_op(4'd5, 16'h0, 11'd0, 2'd0, 13'sd18, 2'd0, 1'b0, 11'd0, 0, "R8 set offset");
        for (int k = 0; k < 4; k++)
            run_op(4'd6, 16'h1000 + 16'(k), 11'd600, 2'd0, 13'sd0, 2'd3, 1'b0, 11'd0, 0, "R9 stream pair");
        chk(mem[604] == 32'h1001_1000 && mem[605] == 32'h1003_1002, "R9 pair order", mem[605], 32'h1003_1002);
        run_op(4'd6, 16'h5555, 11'd700, 2'd0, 13'sd0, 2'd0, 1'b0, 11'd0, 0, "R9 half before reload");
        run_op(4'd5, 16'h0, 11'd0, 2'd0, 13'sd40, 2'd0, 1'b0, 11'd0, 0, "R8 reload mid pair");
        run_op(4'd6, 16'h6666, 11'd700, 2'd0, 13'sd0, 2'd0, 1'b0, 11'd0, 0, "R8 half restarts lower");
        chk(mem[710][15:0] == 16'h6666, "R8 toggle cleared", mem[710], 32'h6666);

        // R10 streaming full
        run_op(4'd7, 16'h7777, 11'd800, 2'd0, 13'sd0, 2'd2, 1'b0, 11'd9, 0, "R10 stream full a");
        run_op(4'd7, 16'h8888, 11'd800, 2'd0, 13'sd0, 2'd2, 1'b0, 11'd9, 0, "R10 stream full b");

        // R11 loads
        mem[900] = 32'h1234_5678;
        run_op(4'd8, 16'h0, 11'd900, 2'd0, 13'sd0, 2'd0, 1'b0, 11'd0, 1, "R11 load low");
        run_op(4'd9, 16'h0, 11'd900, 2'd0, 13'sd0, 2'd0, 1'b0, 11'd0, 0, "R11 load high");

        // R3 long stall, R12 unknown codes
        run_op(4'd1, 16'h4321, 11'd950, 2'd1, 13'sd4, 2'd0, 1'b0, 11'd3, 5, "R3 long stall");
        run_op(4'd12, 16'h9999, 11'd960, 2'd0, 13'sd0, 2'd0, 1'b0, 11'd0, 0, "R12 unused code");
        run_op(4'd0, 16'h9999, 11'd960, 2'd0, 13'sd0, 2'd0, 1'b0, 11'd0, 0, "R12 code zero");
        chk(mem[960] == 32'h0, "R12 memory untouched", mem[960], 32'h0);

        // R2 request while busy is ignored
        begin
            int wc0;
            wc0 = wr_cnt;
            @(negedge clk);
            op_valid = 1'b1; op_code = 4'd1; src_val = 16'h0F0F; base_val = 11'd1000;
            base_idx = 2'd0; byte_off = 13'sd0; pc = 11'd0;
            @(negedge clk);
            chk(busy, "R2 busy after accept", busy, 1);
            base_val = 11'd1001;
            @(negedge clk);
            op_valid = 1'b0;
            cnt = 0;
            repeat (8) begin
                @(negedge clk);
                if (done) cnt++;
            end
            chk(cnt == 1 && wr_cnt == wc0 + 1 && mem[1001] == 32'h0, "R2 busy request ignored", cnt, 1);
        end

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [3:0] op;
            op = 4'($urandom_range(0, 10));
            run_op(op, 16'($urandom), 11'($urandom), 2'($urandom), 13'($urandom), 2'($urandom),
                   1'($urandom), 11'($urandom), int'($urandom_range(0, 3)), "R4 R7 R10 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule